// File: doc/BRIEF.md
# Pattern-Unlocked Serial Register Port

This block listens on a byte-wide asynchronous memory bus and finds a hidden access sequence in the ordinary traffic. It never touches the memory array. It only raises an inhibit signal while it owns the bus. Before it unlocks, every cycle goes to memory, and the writes that carry the key go to memory as well. The block samples the chip-enable, output-enable and write-enable strobes and data bit 0 with its system clock. A cycle starts when synchronised chip enable falls. The cycle type is decided at that point, and the cycle is acted on when chip enable rises again.

Software opens the port in three steps. It reads any address. It then writes a 64-bit key, one bit per write cycle, on data bit 0. After that it performs 64 transfer cycles. Each transfer cycle reads or writes one bit of a 64-bit register file, built as eight bytes. Reads drive data bit 0. Written bytes are stored only when the whole byte has arrived. The port then locks again. An external abort input can end a transfer early, but only if a control bit inside the register file allows it.

Top module: `keyed_serial_port`

## Requirements
- R1: After reset, mem_inhibit and bus_d0_drive are low and regfile_q equals the reset image. The default image is 0x0000_0030_0000_0000, which sets bits 36 and 37.
- R2: After reset, the matcher ignores key writes until a read cycle has been seen. A full key with no read before it leaves mem_inhibit low.
- R3: A read cycle rewinds the key pointer to bit 0 and starts a new match. A read part-way through the key discards the bits matched so far.
- R4: The key is the 64-bit value 0x5CA33AC5_5CA33AC5, sent LSB first on data bit 0. Bit i of the key is sent in write i. When all 64 writes match, mem_inhibit goes high.
- R5: On a key-bit mismatch the pointer stops, and all later writes are ignored until the next read. Correct bits after the error do not unlock the port.
- R6: mem_inhibit stays low for every key write cycle, including the 64th.
- R7: Transfer cycle n (0 to 63) accesses register n/8, bit n%8, which is regfile_q bit n. A read cycle (we_n high, oe_n low) drives bus_d0_drive high with that bit on bus_d0_out.
- R8: A written byte is stored only after all eight of its bits have been written. A partial byte leaves regfile_q unchanged.
- R9: After the 64th read or write transfer cycle, mem_inhibit goes low. Unlocking again needs a new read followed by the full key.
- R10: During a transfer, a low on xfer_abort_n ends the transfer and leaves regfile_q unchanged, but only while regfile_q bit 36 is 0. When that bit is 1, the abort input has no effect.
- R11: A cycle with chip enable low but both write enable and output enable high does not count as a transfer cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| bus_oe_n | input | 1 | Bus output enable, active low, asynchronous |
| bus_we_n | input | 1 | Bus write enable, active low, asynchronous |
| bus_d0_in | input | 1 | Data bit 0 as seen on the bus |
| xfer_abort_n | input | 1 | Transfer abort request, active low |
| bus_d0_out | output | 1 | Bit driven on data bit 0 during transfer reads |
| bus_d0_drive | output | 1 | High while the block drives data bit 0 |
| mem_inhibit | output | 1 | High while memory access must be blocked |
| regfile_q | output | 64 | Register file contents; register k occupies bits 8k+7 to 8k |

## Verification
The state that matters here is held in the key pointer, the transfer counter and the byte staging mask. None of it is visible until it goes wrong. A pointer that advances wrongly shows at mem_inhibit only at the end of a key, up to 64 bus cycles later, so every key scenario also checks the opposite outcome, where the port must stay locked. A transfer counter that is off by one shows within the first byte as a shifted bus_d0_out value. It also changes the cycle on which mem_inhibit falls. A staging fault shows in regfile_q only when a byte is committed or wrongly held back, so partial bytes and aborted transfers are checked against the stored image.

// File: rtl/keyed_serial_pkg.sv
// Shared constants and types for the keyed serial register port.
// Assumes a fixed 64-bit unlock key sent least significant bit first.
package keyed_serial_pkg;

    localparam int KEY_BITS = 64;
    localparam logic [KEY_BITS-1:0] UNLOCK_KEY = 64'h5CA3_3AC5_5CA3_3AC5;

    typedef enum logic [1:0] {
        CYC_NONE  = 2'd0,
        CYC_WRITE = 2'd1,
        CYC_READ  = 2'd2
    } cyc_kind_e;

    typedef enum logic {
        MT_DEAD = 1'b0,
        MT_HUNT = 1'b1
    } match_state_e;

endpackage

// File: rtl/keyed_serial_sync.sv
// Synchronises the asynchronous bus strobes and data bit 0, and turns them
// into cycle events. The cycle type is latched when synchronised chip enable
// falls. One event pulse with the type and data bit is issued when chip
// enable rises. Assumes strobes are stable for several clock periods.
module keyed_serial_sync
    import keyed_serial_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      raw_ce_n,
    input  logic      raw_oe_n,
    input  logic      raw_we_n,
    input  logic      raw_d0,
    input  logic      raw_abort_n,
    output logic      evt_valid,
    output cyc_kind_e evt_kind,
    output logic      evt_bit,
    output cyc_kind_e cur_kind,
    output logic      abort_req
);

    localparam int NSIG = 5;
    localparam logic [NSIG-1:0] IDLE_VEC = 5'b10111;

    logic [NSIG-1:0] raw_vec;
    logic [NSIG-1:0] chain [STAGES];
    logic [NSIG-1:0] synced;
    logic            ce_s, oe_s, we_s, d0_s, abort_s;
    logic            ce_prev_q;
    logic            in_cyc_q;
    cyc_kind_e       kind_q;
    logic            cyc_start, cyc_end;

    assign raw_vec = {raw_abort_n, raw_d0, raw_we_n, raw_oe_n, raw_ce_n};

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_sync
            // Purpose: one stage of the synchroniser chain for all inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= IDLE_VEC;
                end else if (s == 0) begin
                    chain[s] <= raw_vec;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign synced  = chain[STAGES-1];
    assign ce_s    = synced[0];
    assign oe_s    = synced[1];
    assign we_s    = synced[2];
    assign d0_s    = synced[3];
    assign abort_s = synced[4];

    assign cyc_start = ce_prev_q && !ce_s;
    assign cyc_end   = !ce_prev_q && ce_s;

    // Purpose: track chip enable and classify each cycle at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_prev_q <= 1'b1;
            in_cyc_q  <= 1'b0;
            kind_q    <= CYC_NONE;
        end else begin
            ce_prev_q <= ce_s;
            if (cyc_start) begin
                in_cyc_q <= 1'b1;
                if (!we_s)
                    kind_q <= CYC_WRITE;
                else if (!oe_s)
                    kind_q <= CYC_READ;
                else
                    kind_q <= CYC_NONE;
            end else if (cyc_end) begin
                in_cyc_q <= 1'b0;
            end
        end
    end

    // Purpose: issue one event per completed cycle with its data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_kind  <= CYC_NONE;
            evt_bit   <= 1'b0;
        end else begin
            evt_valid <= cyc_end;
            evt_kind  <= kind_q;
            evt_bit   <= d0_s;
        end
    end

    assign cur_kind  = in_cyc_q ? kind_q : CYC_NONE;
    assign abort_req = !abort_s;

    // A completed cycle produces exactly one event pulse.
    evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);

endmodule

// File: rtl/keyed_serial_matcher.sv
// Compares write-cycle data bits with the unlock key. A read rewinds the
// pointer and arms the match. A mismatch freezes the pointer until the next
// read. A full match gives a one-clock unlock pulse. While the transfer
// engine is busy, the matcher is held disarmed, so a fresh read is needed.
module keyed_serial_matcher
    import keyed_serial_pkg::*;
#(
    parameter int                  NBITS = KEY_BITS,
    parameter logic [NBITS-1:0]    KEY   = UNLOCK_KEY
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      evt_valid,
    input  cyc_kind_e evt_kind,
    input  logic      evt_bit,
    input  logic      busy,
    output logic      unlock
);

    localparam int PW = $clog2(NBITS);
    localparam logic [PW-1:0] LAST = PW'(NBITS - 1);

    match_state_e    state_q;
    logic [PW-1:0]   ptr_q;
    logic            key_bit;

    assign key_bit = KEY[ptr_q];

    // Purpose: key pointer and arm state update on each bus event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MT_DEAD;
            ptr_q   <= '0;
            unlock  <= 1'b0;
        end else begin
            unlock <= 1'b0;
            if (busy) begin
                state_q <= MT_DEAD;
                ptr_q   <= '0;
            end else if (evt_valid) begin
                if (evt_kind == CYC_READ) begin
                    state_q <= MT_HUNT;
                    ptr_q   <= '0;
                end else if (evt_kind == CYC_WRITE && state_q == MT_HUNT) begin
                    if (evt_bit == key_bit) begin
                        if (ptr_q == LAST) begin
                            unlock  <= 1'b1;
                            state_q <= MT_DEAD;
                            ptr_q   <= '0;
                        end else begin
                            ptr_q <= ptr_q + 1'b1;
                        end
                    end else begin
                        state_q <= MT_DEAD;
                    end
                end
            end
        end
    end

    // R3
    read_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == CYC_READ && !busy)
        |=> (ptr_q == '0 && state_q == MT_HUNT));

    // R5
    miss_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == CYC_WRITE && state_q == MT_HUNT && !busy
         && evt_bit != KEY[ptr_q])
        |=> (state_q == MT_DEAD && ptr_q == $past(ptr_q)));

    // R5
    dead_no_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MT_DEAD && !busy) |=> !unlock);

endmodule

// File: rtl/keyed_serial_engine.sv
// Serial transfer engine for the register file. After unlock, it counts
// 64 read/write bus cycles. Cycle n addresses register n/8, bit n%8. Reads
// drive the addressed bit. Writes collect into a staging byte, which is
// committed only when all eight bits have been written. An abort request
// ends the transfer when the abort-enable bit in the file is clear.
module keyed_serial_engine
    import keyed_serial_pkg::*;
#(
    parameter int                     REG_BYTES   = 8,
    parameter int                     RST_EN_BIT  = 36,
    parameter logic [REG_BYTES*8-1:0] RESET_IMAGE = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   unlock,
    input  logic                   evt_valid,
    input  cyc_kind_e              evt_kind,
    input  logic                   evt_bit,
    input  cyc_kind_e              cur_kind,
    input  logic                   abort_req,
    output logic                   active,
    output logic                   d0_out,
    output logic                   d0_drive,
    output logic [REG_BYTES*8-1:0] regs_flat
);

    localparam int TOTAL = REG_BYTES * 8;
    localparam int CW    = $clog2(TOTAL);
    localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

    logic [7:0]    regs_q [REG_BYTES];
    logic [CW-1:0] cnt_q;
    logic [7:0]    stage_q, stage_nx;
    logic [7:0]    mask_q, mask_nx, mask_base;
    logic [2:0]    bit_sel;
    logic [CW-4:0] byte_sel;
    logic          xfer_evt;
    logic          abort_ok;

    generate
        for (genvar k = 0; k < REG_BYTES; k++) begin : g_flat
            assign regs_flat[k*8 +: 8] = regs_q[k];
        end
    endgenerate

    assign bit_sel   = cnt_q[2:0];
    assign byte_sel  = cnt_q[CW-1:3];
    assign xfer_evt  = evt_valid && (evt_kind == CYC_WRITE || evt_kind == CYC_READ);
    assign abort_ok  = abort_req && !regs_flat[RST_EN_BIT];

    // Purpose: next staging byte and mask for a write transfer cycle.
    always_comb begin
        mask_base         = (bit_sel == 3'd0) ? 8'h00 : mask_q;
        mask_nx           = mask_base | (8'h01 << bit_sel);
        stage_nx          = stage_q;
        stage_nx[bit_sel] = evt_bit;
    end

    // Purpose: transfer sequencing, byte staging and register commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt_q   <= '0;
            stage_q <= '0;
            mask_q  <= '0;
            for (int i = 0; i < REG_BYTES; i++)
                regs_q[i] <= RESET_IMAGE[i*8 +: 8];
        end else if (!active) begin
            if (unlock) begin
                active <= 1'b1;
                cnt_q  <= '0;
                mask_q <= '0;
            end
        end else if (abort_ok) begin
            active <= 1'b0;
            cnt_q  <= '0;
            mask_q <= '0;
        end else if (xfer_evt) begin
            if (evt_kind == CYC_WRITE) begin
                stage_q <= stage_nx;
                mask_q  <= mask_nx;
                if (bit_sel == 3'd7 && mask_nx == 8'hFF)
                    regs_q[byte_sel] <= stage_nx;
            end else begin
                mask_q <= mask_base;
            end
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST)
                active <= 1'b0;
        end
    end

    assign d0_drive = active && (cur_kind == CYC_READ);
    assign d0_out   = d0_drive && regs_q[byte_sel][bit_sel];

    // R10
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && abort_ok) |=> !active);

    // R10
    abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && abort_ok) |=> $stable(regs_flat));

    // R9
    last_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !abort_ok && xfer_evt && cnt_q == LAST) |=> !active);

    // R11
    idle_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !abort_ok && evt_valid && evt_kind == CYC_NONE)
        |=> (active && $stable(cnt_q)));

    // R8
    partial_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && xfer_evt && bit_sel != 3'd7) |=> $stable(regs_flat));

endmodule

// File: rtl/keyed_serial_port.sv
// Top level of the keyed serial register port. It connects the bus
// synchroniser, the key matcher and the transfer engine. mem_inhibit is
// high for the whole transfer window. Assumes the memory array honours it.
module keyed_serial_port
    import keyed_serial_pkg::*;
#(
    parameter int                     SYNC_STAGES = 2,
    parameter int                     REG_BYTES   = 8,
    parameter int                     RST_EN_BIT  = 36,
    parameter logic [REG_BYTES*8-1:0] RESET_IMAGE = 64'h0000_0030_0000_0000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_ce_n,
    input  logic                   bus_oe_n,
    input  logic                   bus_we_n,
    input  logic                   bus_d0_in,
    input  logic                   xfer_abort_n,
    output logic                   bus_d0_out,
    output logic                   bus_d0_drive,
    output logic                   mem_inhibit,
    output logic [REG_BYTES*8-1:0] regfile_q
);

    logic      evt_valid;
    cyc_kind_e evt_kind;
    logic      evt_bit;
    cyc_kind_e cur_kind;
    logic      abort_req;
    logic      unlock;
    logic      active;

    keyed_serial_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_ce_n   (bus_ce_n),
        .raw_oe_n   (bus_oe_n),
        .raw_we_n   (bus_we_n),
        .raw_d0     (bus_d0_in),
        .raw_abort_n(xfer_abort_n),
        .evt_valid  (evt_valid),
        .evt_kind   (evt_kind),
        .evt_bit    (evt_bit),
        .cur_kind   (cur_kind),
        .abort_req  (abort_req)
    );

    keyed_serial_matcher #(.NBITS(KEY_BITS), .KEY(UNLOCK_KEY)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_valid(evt_valid),
        .evt_kind (evt_kind),
        .evt_bit  (evt_bit),
        .busy     (active),
        .unlock   (unlock)
    );

    keyed_serial_engine #(
        .REG_BYTES  (REG_BYTES),
        .RST_EN_BIT (RST_EN_BIT),
        .RESET_IMAGE(RESET_IMAGE)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .unlock   (unlock),
        .evt_valid(evt_valid),
        .evt_kind (evt_kind),
        .evt_bit  (evt_bit),
        .cur_kind (cur_kind),
        .abort_req(abort_req),
        .active   (active),
        .d0_out   (bus_d0_out),
        .d0_drive (bus_d0_drive),
        .regs_flat(regfile_q)
    );

    assign mem_inhibit = active;

    // R7
    drive_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_d0_drive |-> mem_inhibit);

    // R6
    key_not_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |-> !mem_inhibit);

endmodule

// File: tb/keyed_serial_port_tb.sv
`timescale 1ns/1ps
module keyed_serial_port_tb;
    import keyed_serial_pkg::*;

    localparam logic [63:0] RST_IMG = 64'h0000_0030_0000_0000;
    localparam logic [63:0] PAT_A   = 64'h1122_3344_0F66_7788; // reg4=0x44, bit36=0
    localparam logic [63:0] PAT_B   = 64'hA5A5_A510_5A5A_5A5A; // reg4=0x10, bit36=1
    localparam int KIND_NONE = 0, KIND_WR = 1, KIND_RD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, d0 = 1'b0, abort_n = 1'b1;
    logic d0_out, d0_drive, inhibit;
    logic [63:0] regs;
    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    keyed_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n),
        .bus_we_n(we_n), .bus_d0_in(d0), .xfer_abort_n(abort_n),
        .bus_d0_out(d0_out), .bus_d0_drive(d0_drive),
        .mem_inhibit(inhibit), .regfile_q(regs)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_cycle(input int kind, input logic b,
                             output logic rb, output logic drv, output logic inh);
        @(negedge clk);
        d0   = b;
        ce_n = 1'b0;
        we_n = (kind == KIND_WR) ? 1'b0 : 1'b1;
        oe_n = (kind == KIND_RD) ? 1'b0 : 1'b1;
        repeat (6) @(negedge clk);
        rb  = d0_out;
        drv = d0_drive;
        inh = inhibit;
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic do_read();
        logic rb, drv, inh;
        bus_cycle(KIND_RD, 1'b0, rb, drv, inh);
    endtask

    task automatic key_writes(input int first, input int count);
        logic rb, drv, inh;
        for (int i = first; i < first + count; i++)
            bus_cycle(KIND_WR, UNLOCK_KEY[i], rb, drv, inh);
    endtask

    task automatic unlock_seq();
        do_read();
        key_writes(0, 64);
    endtask

    task automatic write_image(input logic [63:0] img);
        logic rb, drv, inh;
        for (int i = 0; i < 64; i++)
            bus_cycle(KIND_WR, img[i], rb, drv, inh);
    endtask

    task automatic t_reset();
        chk("R1", "inhibit after reset", {63'd0, inhibit}, 64'd0);
        chk("R1", "drive after reset", {63'd0, d0_drive}, 64'd0);
        chk("R1", "regfile after reset", regs, RST_IMG);
    endtask

    task automatic t_no_read();
        key_writes(0, 64);
        chk("R2", "key without read", {63'd0, inhibit}, 64'd0);
    endtask

    task automatic t_unlock_write();
        logic rb, drv, inh;
        do_read();
        key_writes(0, 63);
        bus_cycle(KIND_WR, UNLOCK_KEY[63], rb, drv, inh);
        chk("R6", "inhibit during last key write", {63'd0, inh}, 64'd0);
        chk("R4", "inhibit after full key", {63'd0, inhibit}, 64'd1);
        for (int i = 0; i < 63; i++) begin
            bus_cycle(KIND_WR, PAT_A[i], rb, drv, inh);
            if (i == 10 || i == 40 || i == 61)
                bus_cycle(KIND_NONE, 1'b1, rb, drv, inh);
        end
        chk("R11", "still open after 63 plus idle cycles", {63'd0, inhibit}, 64'd1);
        bus_cycle(KIND_WR, PAT_A[63], rb, drv, inh);
        chk("R9", "locked after 64th write", {63'd0, inhibit}, 64'd0);
        chk("R7", "written image", regs, PAT_A);
    endtask

    task automatic t_read_out();
        logic rb, drv, inh;
        logic [63:0] got;
        logic all_drv;
        got = '0;
        all_drv = 1'b1;
        unlock_seq();
        for (int i = 0; i < 64; i++) begin
            bus_cycle(KIND_RD, 1'b0, rb, drv, inh);
            got[i] = rb;
            all_drv = all_drv & drv;
        end
        chk("R7", "serial read image", got, PAT_A);
        chk("R7", "drive on every read", {63'd0, all_drv}, 64'd1);
        chk("R9", "locked after 64 reads", {63'd0, inhibit}, 64'd0);
        key_writes(0, 64);
        chk("R9", "key after transfer needs read", {63'd0, inhibit}, 64'd0);
    endtask

    task automatic t_mismatch();
        logic rb, drv, inh;
        do_read();
        key_writes(0, 10);
        bus_cycle(KIND_WR, ~UNLOCK_KEY[10], rb, drv, inh);
        key_writes(11, 53);
        chk("R5", "mismatch blocks unlock", {63'd0, inhibit}, 64'd0);
        key_writes(0, 64);
        chk("R5", "writes ignored until read", {63'd0, inhibit}, 64'd0);
    endtask

    task automatic t_read_abort_and_pin();
        logic rb, drv, inh;
        do_read();
        key_writes(0, 20);
        do_read();
        key_writes(20, 44);
        chk("R3", "read mid-key discards progress", {63'd0, inhibit}, 64'd0);
        do_read();
        key_writes(0, 20);
        do_read();
        key_writes(0, 64);
        chk("R3", "read restarts match", {63'd0, inhibit}, 64'd1);
        for (int i = 0; i < 4; i++)
            bus_cycle(KIND_WR, 1'b1, rb, drv, inh);
        chk("R8", "partial byte not stored", regs, PAT_A);
        @(negedge clk); abort_n = 1'b0;
        repeat (8) @(negedge clk); abort_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10", "abort ends transfer", {63'd0, inhibit}, 64'd0);
        chk("R10", "abort keeps registers", regs, PAT_A);
    endtask

    task automatic t_pin_ignored();
        logic rb, drv, inh;
        logic [63:0] got;
        got = '0;
        unlock_seq();
        write_image(PAT_B);
        chk("R8", "full image B stored", regs, PAT_B);
        unlock_seq();
        @(negedge clk); abort_n = 1'b0;
        repeat (8) @(negedge clk); abort_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10", "abort ignored when enable bit set", {63'd0, inhibit}, 64'd1);
        for (int i = 0; i < 64; i++) begin
            bus_cycle(KIND_RD, 1'b0, rb, drv, inh);
            got[i] = rb;
        end
        chk("R10", "read after ignored abort", got, PAT_B);
        chk("R9", "locked after read-out", {63'd0, inhibit}, 64'd0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_no_read();
        t_unlock_write();
        t_read_out();
        t_mismatch();
        t_read_abort_and_pin();
        t_pin_ignored();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule